// File: doc/BRIEF.md
# Serial Link-Up Status Sequencer

This block decides when each direction of a multi-lane serial streaming link may be reported as up. It watches a management reset, a transmit PLL-lock indication and one ready bit per lane in each direction. From these it drives a transmit link flag and a receive link flag. It also drives a user-domain reset for each direction, which stays low only while that direction is up. Every input passes through a two-flop synchronizer first. A direction is declared up only after its complete ready condition has held for a set number of consecutive cycles.

The transmit side follows a fixed chain of waits: the management reset must release, then the PLL must lock, then every transmit lane must report ready. The receive side waits for the reset to release and then for every receive lane to be ready. A build parameter selects a transceiver variant whose transmit side has no PLL step. The two sides run on their own state machines, so one direction can be up while the other is still waiting. If a condition is lost, the affected side falls back to the wait state that matches the loss.

Top module: `linkup_seq`

## Requirements
- R1: After `rst_n` releases, and whenever the synchronized management reset is high, both link flags are 0 and both user resets are 1. This holds even when every other input is ready. When `mgmt_rst` falls and every other input is already ready, `rx_up` rises in the 7th clock and `tx_up` rises in the 8th clock (default variant).
- R2: In the default variant (`SKIP_PLL`=0), `tx_up` stays 0 while `pll_lock` is 0, even with all transmit lanes ready. If the transmit lanes are already ready, `tx_up` rises in the 7th clock after `pll_lock` rises.
- R3: `tx_lane_ok` and `rx_lane_ok` carry one bit per lane, with bit i belonging to lane i. A side is up only when every bit of its vector is 1. A single 0 bit, at either end of the vector, keeps the side down.
- R4: The full ready condition must be seen for `HOLD_CYCLES` (default 4) consecutive cycles before a side goes up. In a lane-wait state, the flag therefore rises in clock 2+`HOLD_CYCLES` (6) after the last lane becomes ready. An interruption of even one cycle restarts the count.
- R5: A side that is up drops its flag in the 3rd clock after one of its conditions is lost (two synchronizer stages plus one state update). The conditions are the management reset, the PLL lock (default transmit side) and any lane's ready bit. A side that lost only lane readiness returns to lane-wait and comes back up in the 6th clock after the lanes recover. A transmit side that lost PLL lock returns to PLL-wait and comes back up in the 7th clock after the lock returns.
- R6: On each side, the user reset is 1 exactly when the link flag is 0.
- R7: The receive side never depends on `pll_lock` or on the transmit side. `rx_up` can rise and stay up while the transmit side waits for PLL lock.
- R8: With `SKIP_PLL`=1, the transmit side ignores `pll_lock`. It rises in the 6th clock after all transmit lanes are ready, and it stays up when `pll_lock` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| mgmt_rst | input | 1 | Management reset, active high, asynchronous to clk |
| pll_lock | input | 1 | All transmit PLLs locked, asynchronous to clk |
| tx_lane_ok | input | NUM_LANES | Per-lane transmit ready, bit i = lane i |
| rx_lane_ok | input | NUM_LANES | Per-lane receive ready, bit i = lane i |
| tx_up | output | 1 | Transmit link up |
| rx_up | output | 1 | Receive link up |
| tx_usr_rst | output | 1 | Transmit user-domain reset, active high |
| rx_usr_rst | output | 1 | Receive user-domain reset, active high |

## Verification
A default-variant instance and a PLL-skipping instance share the same stimulus, so each comparison shows how the two transmit paths differ. Lanes are raised with the PLL unlocked and then the PLL is locked. This separates the receive side, which ignores the PLL, from the transmit side, which waits for it. Single-lane drops at the top and bottom bit show that a plain OR reduction or a partial lane check is wrong. A one-cycle ready dropout in the middle of a hold window shows whether the count restarts or merely pauses. The return times after a lane loss, a PLL loss and a management reset differ by design (6, 7 and 7/8 clocks). Those timings show which wait state each side fell back to.

// File: rtl/lus_pkg.sv
package lus_pkg;

  typedef enum logic [1:0] {
    ST_RESET      = 2'd0,
    ST_WAIT_PLL   = 2'd1,
    ST_WAIT_LANES = 2'd2,
    ST_LINK_UP    = 2'd3
  } lus_state_e;

  // Bits needed for a counter that reaches hold-1.
  function automatic int cnt_width(input int hold);
    return $clog2(hold) + 1;
  endfunction

  // True when the current count closes a hold window of the given length.
  function automatic bit hold_reached(input int cnt, input int hold);
    return cnt >= hold - 1;
  endfunction

  // Clocks from an input change to a visible link drop.
  function automatic int drop_latency(input int stages);
    return stages + 1;
  endfunction

endpackage

// File: rtl/lus_sync.sv
module lus_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/lus_side_fsm.sv
module lus_side_fsm
  import lus_pkg::*;
#(
  parameter bit HAS_PLL     = 1'b1,
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_s,
  input  logic pll_ok,
  input  logic lanes_ok,
  output logic link_up,
  output logic user_rst
);

  localparam int CW = cnt_width(HOLD_CYCLES);

  lus_state_e    st, nxt;
  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    nxt     = st;
    cnt_nxt = '0;
    if (rst_s) begin
      nxt = ST_RESET;
    end else begin
      unique case (st)
        ST_RESET: begin
          nxt = HAS_PLL ? ST_WAIT_PLL : ST_WAIT_LANES;
        end
        ST_WAIT_PLL: begin
          if (pll_ok) nxt = ST_WAIT_LANES;
        end
        ST_WAIT_LANES: begin
          if (!pll_ok) begin
            nxt = ST_WAIT_PLL;
          end else if (lanes_ok) begin
            if (hold_reached(int'(cnt), HOLD_CYCLES)) nxt = ST_LINK_UP;
            else                                      cnt_nxt = cnt + 1'b1;
          end
        end
        ST_LINK_UP: begin
          if (!pll_ok)       nxt = ST_WAIT_PLL;
          else if (!lanes_ok) nxt = ST_WAIT_LANES;
        end
        default: nxt = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_RESET;
      cnt      <= '0;
      user_rst <= 1'b1;
    end else begin
      st       <= nxt;
      cnt      <= cnt_nxt;
      user_rst <= (nxt != ST_LINK_UP);
    end
  end

  assign link_up = (st == ST_LINK_UP);

endmodule

// File: rtl/linkup_seq.sv
module linkup_seq
  import lus_pkg::*;
#(
  parameter int NUM_LANES   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4,
  parameter bit SKIP_PLL    = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mgmt_rst,
  input  logic                 pll_lock,
  input  logic [NUM_LANES-1:0] tx_lane_ok,
  input  logic [NUM_LANES-1:0] rx_lane_ok,
  output logic                 tx_up,
  output logic                 rx_up,
  output logic                 tx_usr_rst,
  output logic                 rx_usr_rst
);

  localparam int SW = 2 + 2 * NUM_LANES;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {(SW-1){1'b0}}};

  logic [SW-1:0]        sync_q;
  logic                 mgmt_rst_s;
  logic                 pll_s;
  logic [NUM_LANES-1:0] tx_lanes_s;
  logic [NUM_LANES-1:0] rx_lanes_s;

  // Named internal events used by the checker.
  logic tx_pll_ok;
  logic tx_lanes_ok;
  logic rx_lanes_ok;

  lus_sync #(
    .WIDTH   (SW),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({mgmt_rst, pll_lock, tx_lane_ok, rx_lane_ok}),
    .q     (sync_q)
  );

  assign {mgmt_rst_s, pll_s, tx_lanes_s, rx_lanes_s} = sync_q;

  assign tx_lanes_ok = &tx_lanes_s;
  assign rx_lanes_ok = &rx_lanes_s;

  generate
    if (SKIP_PLL) begin : g_no_pll
      assign tx_pll_ok = 1'b1;
    end else begin : g_pll
      assign tx_pll_ok = pll_s;
    end
  endgenerate

  lus_side_fsm #(
    .HAS_PLL     (!SKIP_PLL),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_tx_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_s    (mgmt_rst_s),
    .pll_ok   (tx_pll_ok),
    .lanes_ok (tx_lanes_ok),
    .link_up  (tx_up),
    .user_rst (tx_usr_rst)
  );

  lus_side_fsm #(
    .HAS_PLL     (1'b0),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_rx_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_s    (mgmt_rst_s),
    .pll_ok   (1'b1),
    .lanes_ok (rx_lanes_ok),
    .link_up  (rx_up),
    .user_rst (rx_usr_rst)
  );

endmodule

// File: rtl/lus_chk.sv
module lus_chk #(
  parameter int HOLD_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic mgmt_rst_s,
  input logic tx_pll_ok,
  input logic tx_lanes_ok,
  input logic rx_lanes_ok,
  input logic tx_up,
  input logic rx_up,
  input logic tx_usr_rst,
  input logic rx_usr_rst
);

  int tx_run;
  int rx_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_run <= 0;
      rx_run <= 0;
    end else begin
      if (mgmt_rst_s || !(tx_pll_ok && tx_lanes_ok)) tx_run <= 0;
      else if (tx_run < HOLD_CYCLES)                 tx_run <= tx_run + 1;
      if (mgmt_rst_s || !rx_lanes_ok)                rx_run <= 0;
      else if (rx_run < HOLD_CYCLES)                 rx_run <= rx_run + 1;
    end
  end

  a_r1_reset_holds_down: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_rst_s |=> (!tx_up && !rx_up));

  a_r2_pll_before_up: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_up) |-> $past(tx_pll_ok));

  a_r4_tx_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_up) |-> (tx_run >= HOLD_CYCLES));

  a_r4_rx_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_up) |-> (rx_run >= HOLD_CYCLES));

  a_r5_tx_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_up && (mgmt_rst_s || !tx_pll_ok || !tx_lanes_ok)) |=> !tx_up);

  a_r5_rx_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_up && (mgmt_rst_s || !rx_lanes_ok)) |=> !rx_up);

  a_r6_tx_rst_pair: assert property (@(posedge clk) disable iff (!rst_n)
    tx_up != tx_usr_rst);

  a_r6_rx_rst_pair: assert property (@(posedge clk) disable iff (!rst_n)
    rx_up != rx_usr_rst);

endmodule

bind linkup_seq lus_chk #(
  .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mgmt_rst_s  (mgmt_rst_s),
  .tx_pll_ok   (tx_pll_ok),
  .tx_lanes_ok (tx_lanes_ok),
  .rx_lanes_ok (rx_lanes_ok),
  .tx_up       (tx_up),
  .rx_up       (rx_up),
  .tx_usr_rst  (tx_usr_rst),
  .rx_usr_rst  (rx_usr_rst)
);

// File: tb/linkup_seq_tb.sv
module linkup_seq_tb;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mgmt_rst = 1'b1;
  logic         pll_lock = 1'b0;
  logic [N-1:0] tx_lane_ok = '0;
  logic [N-1:0] rx_lane_ok = '0;

  logic tx_up, rx_up, tx_usr_rst, rx_usr_rst;
  logic a_tx_up, a_rx_up, a_tx_usr_rst, a_rx_usr_rst;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    int    at;
    logic  tx;
    logic  rx;
    logic  alt;
    string tag;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  linkup_seq #(.NUM_LANES(N), .SKIP_PLL(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .mgmt_rst(mgmt_rst), .pll_lock(pll_lock),
    .tx_lane_ok(tx_lane_ok), .rx_lane_ok(rx_lane_ok),
    .tx_up(tx_up), .rx_up(rx_up), .tx_usr_rst(tx_usr_rst), .rx_usr_rst(rx_usr_rst)
  );

  linkup_seq #(.NUM_LANES(N), .SKIP_PLL(1'b1)) u_alt (
    .clk(clk), .rst_n(rst_n), .mgmt_rst(mgmt_rst), .pll_lock(pll_lock),
    .tx_lane_ok(tx_lane_ok), .rx_lane_ok(rx_lane_ok),
    .tx_up(a_tx_up), .rx_up(a_rx_up), .tx_usr_rst(a_tx_usr_rst), .rx_usr_rst(a_rx_usr_rst)
  );

  // Driver side: queue an expectation d clocks from now.
  task automatic expect_at(input int d, input logic tx, input logic rx,
                           input logic alt, input string tag);
    exp_t e;
    e.at  = cyc + d;
    e.tx  = tx;
    e.rx  = rx;
    e.alt = alt;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)",
               tag, what, act, exp, cyc);
    end
  endtask

  // Monitor side: pop and compare the expectations that are due.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, "tx_up",          tx_up,        e.tx);
      cmp(e.tag, "rx_up",          rx_up,        e.rx);
      cmp(e.tag, "alt tx_up",      a_tx_up,      e.alt);
      cmp(e.tag, "R6 tx_usr_rst",  tx_usr_rst,   !e.tx);
      cmp(e.tag, "R6 rx_usr_rst",  rx_usr_rst,   !e.rx);
      cmp(e.tag, "R6 alt tx_rst",  a_tx_usr_rst, !e.alt);
      cmp(e.tag, "alt rx_up",      a_rx_up,      e.rx);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    idle(3);
    rst_n = 1'b1;
    expect_at(1, 0, 0, 0, "R1 after rst_n");
    expect_at(5, 0, 0, 0, "R1 mgmt reset held");
    idle(10);

    // R7 / R8 / R2: lanes ready with PLL unlocked
    mgmt_rst = 1'b0;
    idle(10);
    tx_lane_ok = '1;
    rx_lane_ok = '1;
    expect_at(5,  0, 0, 0, "R4 still counting");
    expect_at(6,  0, 1, 1, "R7 rx up without pll, R8 alt tx up");
    expect_at(15, 0, 1, 1, "R2 tx waits for pll");
    idle(16);

    // R2: PLL lock arrives
    pll_lock = 1'b1;
    expect_at(6, 0, 1, 1, "R2 tx not yet up");
    expect_at(7, 1, 1, 1, "R2 tx up after pll");
    idle(10);

    // R3 / R5: top receive lane drops, then recovers
    rx_lane_ok[N-1] = 1'b0;
    expect_at(2,  1, 1, 1, "R5 rx still up");
    expect_at(3,  1, 0, 1, "R5 rx drops");
    expect_at(12, 1, 0, 1, "R3 one rx lane low keeps rx down");
    idle(13);
    rx_lane_ok = '1;
    expect_at(5, 1, 0, 1, "R5 rx still waiting");
    expect_at(6, 1, 1, 1, "R5 rx back from lane wait");
    idle(10);

    // R3 / R4: bottom transmit lane drop, then a one-cycle dropout mid-hold
    tx_lane_ok[0] = 1'b0;
    expect_at(3, 0, 1, 0, "R3 tx lane 0 drop");
    idle(10);
    tx_lane_ok[0] = 1'b1;
    idle(2);
    tx_lane_ok[0] = 1'b0;
    idle(1);
    tx_lane_ok[0] = 1'b1;
    expect_at(4, 0, 1, 0, "R4 dropout restarts count");
    expect_at(5, 0, 1, 0, "R4 count not done");
    expect_at(6, 1, 1, 1, "R4 up after full window");
    idle(10);

    // R5 / R8: PLL loss and return
    pll_lock = 1'b0;
    expect_at(2, 1, 1, 1, "R5 tx still up");
    expect_at(3, 0, 1, 1, "R5 tx drops on pll loss, R8 alt stays");
    idle(10);
    pll_lock = 1'b1;
    expect_at(6, 0, 1, 1, "R5 tx in pll wait");
    expect_at(7, 1, 1, 1, "R5 tx back from pll wait");
    idle(10);

    // R5 / R1: management reset with everything ready
    mgmt_rst = 1'b1;
    expect_at(2,  1, 1, 1, "R5 before mgmt drop");
    expect_at(3,  0, 0, 0, "R5 mgmt reset drops both");
    expect_at(12, 0, 0, 0, "R1 held down with all ready");
    idle(13);
    mgmt_rst = 1'b0;
    expect_at(6, 0, 0, 0, "R1 not yet up");
    expect_at(7, 0, 1, 1, "R1 rx up after release");
    expect_at(8, 1, 1, 1, "R1 tx up after pll wait");
    idle(12);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule